// File: doc/BRIEF.md
# Web Traffic Frame Classifier

This block watches Ethernet frames as they stream past on a 32-bit word interface with valid/ready handshaking, start and end markers, and a one-bit ingress port number. For each frame it decides whether the frame is IPv4 carrying TCP to destination port 80. It then presents one classification result on a separate valid/ready handshake. The result holds a web flag, an egress port, a disposition code and a tag.

The TCP destination port is located at run time. Its offset comes from the header-length nibble of the IP header, so frames whose IP header carries options are still classified correctly. The egress port is the ingress port with its bit inverted, for web and non-web frames alike. A web frame is marked for diversion with code 0 and the classifier's own tag. Any other frame gets code 1, which means "pass on to the next stage", and a tag of zero.

Byte 0 of a frame travels in bits 31:24 of the first word. Frames are whole words long.

Top module: `web_flow_classifier`

## Requirements
- R1: A frame is web only if all three of these hold: bytes 12-13 (word 3, bits 31:16) equal 0x0800; byte 23 (word 5, bits 7:0) equals 6; the TCP destination port equals 80. Failing any one of them makes the frame non-web.
- R2: The header-length nibble is taken from byte 14 (word 3, bits 11:8). The destination port is read from byte offset 4*IHL+16, which is the upper 16 bits of word IHL+4. A value of 80 in the source-port position does not make a frame web.
- R3: A frame whose header-length nibble is below 5 is non-web.
- R4: A frame that ends before its destination-port word arrives is non-web.
- R5: The egress port equals the ingress port of the start word XOR 1, for every frame.
- R6: A web result carries code 0 and tag WEB_TAG (default 0x00A5). A non-web result carries code 1 and tag 0.
- R7: Exactly one result is produced per frame. The result becomes valid in the cycle after the end word is accepted, and its fields stay stable until resReady is seen high.
- R8: inReady is low while a result waits to be taken. Idle cycles with inValid low inside a frame do not change the classification.
- R9: Words accepted outside a frame, meaning after an end word and before the next start word, are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 32 | Frame word, byte 0 in bits 31:24 |
| inValid | input | 1 | Word valid |
| inReady | output | 1 | Word accepted when high together with inValid |
| inSof | input | 1 | Marks the first word of a frame |
| inEof | input | 1 | Marks the last word of a frame |
| inPort | input | 1 | Ingress port number, sampled on the start word |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Result consumed when high together with resValid |
| resIsWeb | output | 1 | Frame is web traffic |
| resOutPort | output | 1 | Egress port |
| resCode | output | 8 | 0 = divert, 1 = forward to next stage |
| resTag | output | 16 | Classifier tag for web frames, else 0 |

## Verification
The embedded assertions check the handshake rules on every cycle. They cover: the result staying stable while it is stalled, inReady staying low while a result is pending, a result appearing only after an accepted end word, the word index never moving backwards inside a frame, and the ingress port latch changing only on a start word. Whether a frame is judged web or non-web depends on its header contents, so only the bench's directed frames can show it. Those frames cover header options, the source-port decoy, short frames, a header length below 5, stray words outside a frame, and idle gaps on the input.

// File: rtl/webcls_pkg.sv
package webcls_pkg;
  localparam int IDX_W = 5;
  localparam int IDX_MAX = (1 << IDX_W) - 1;

  // Per-word strobes from control to datapath
  typedef struct packed {
    logic             take;   // word accepted into the current frame
    logic             first;  // accepted word is a start word
    logic             last;   // accepted word is an end word
    logic [IDX_W-1:0] idx;    // index of accepted word in the frame
  } wordCtl_t;
endpackage

// File: rtl/webcls_ctrl.sv
module webcls_ctrl
  import webcls_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inSof,
  input  logic     inEof,
  output logic     inReady,
  input  logic     resReady,
  output logic     resValid,
  output wordCtl_t ctl
);
  logic             inFrame;
  logic [IDX_W-1:0] wordIdx;
  logic             take;

  assign inReady = !resValid;
  assign take    = inValid && inReady && (inSof || inFrame);

  always_comb begin
    ctl.take  = take;
    ctl.first = take && inSof;
    ctl.last  = take && inEof;
    ctl.idx   = inSof ? '0 : wordIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame  <= 1'b0;
      wordIdx  <= '0;
      resValid <= 1'b0;
    end else begin
      if (take) begin
        inFrame <= !inEof;
        wordIdx <= (ctl.idx == IDX_W'(IDX_MAX)) ? ctl.idx : ctl.idx + 1'b1;
      end
      if (take && inEof)       resValid <= 1'b1;
      else if (resReady)       resValid <= 1'b0;
    end
  end

  // R8: no word is taken while a result is pending
  a_r8_stall_input: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !inReady);

  // R7: a result shows up only after an accepted end word
  a_r7_rise_after_eof: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> $past(inValid && inReady && inEof));

  // R7: a stalled result stays pending
  a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid);

  // R2: the word index only advances inside a frame
  a_r2_idx_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    take && !inSof |=> wordIdx >= $past(wordIdx));
endmodule

// File: rtl/webcls_dp.sv
module webcls_dp
  import webcls_pkg::*;
#(
  parameter logic [15:0] ETYPE_IP  = 16'h0800,
  parameter logic [7:0]  PROTO_TCP = 8'd6,
  parameter logic [15:0] WEB_PORT  = 16'd80,
  parameter int          MIN_IHL   = 5,
  parameter int          TAG_W     = 16,
  parameter logic [TAG_W-1:0] WEB_TAG = 16'h00A5
) (
  input  logic             clk,
  input  logic             rstN,
  input  wordCtl_t         ctl,
  input  logic [31:0]      inData,
  input  logic             inPort,
  output logic             resIsWeb,
  output logic             resOutPort,
  output logic [7:0]       resCode,
  output logic [TAG_W-1:0] resTag
);
  localparam int ETH_WORD   = 3;
  localparam int PROTO_WORD = 5;
  localparam int OFF_W      = 7;

  logic       etypeOk, protoOk, portOk, portSeen, portIn;
  logic [3:0] ihl;
  logic       nEtype, nProto, nPortOk, nSeen, nPortIn;
  logic [3:0] nIhl;
  logic [OFF_W-1:0] portByteOff;
  logic [IDX_W-1:0] portIdx;
  logic       nWeb;

  always_comb begin
    nEtype  = ctl.first ? 1'b0 : etypeOk;
    nProto  = ctl.first ? 1'b0 : protoOk;
    nPortOk = ctl.first ? 1'b0 : portOk;
    nSeen   = ctl.first ? 1'b0 : portSeen;
    nIhl    = ctl.first ? 4'd0 : ihl;
    nPortIn = ctl.first ? inPort : portIn;
    if (ctl.idx == IDX_W'(ETH_WORD)) begin
      nEtype = (inData[31:16] == ETYPE_IP);
      nIhl   = inData[11:8];
    end
    if (ctl.idx == IDX_W'(PROTO_WORD))
      nProto = (inData[7:0] == PROTO_TCP);
    // offset in bytes, split into 8-byte block and word within block
    portByteOff = {1'b0, nIhl, 2'b00} + OFF_W'(16);
    portIdx     = IDX_W'({portByteOff[OFF_W-1:3], portByteOff[2]});
    if (nIhl >= 4'(MIN_IHL) && ctl.idx == portIdx) begin
      nPortOk = (inData[31:16] == WEB_PORT);
      nSeen   = 1'b1;
    end
    nWeb = nEtype && nProto && nSeen && nPortOk && (nIhl >= 4'(MIN_IHL));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      etypeOk <= 1'b0; protoOk <= 1'b0; portOk <= 1'b0;
      portSeen <= 1'b0; portIn <= 1'b0; ihl <= 4'd0;
      resIsWeb <= 1'b0; resOutPort <= 1'b0;
      resCode <= 8'd0; resTag <= '0;
    end else begin
      if (ctl.take) begin
        etypeOk <= nEtype; protoOk <= nProto; portOk <= nPortOk;
        portSeen <= nSeen; portIn <= nPortIn; ihl <= nIhl;
      end
      if (ctl.last) begin
        resIsWeb   <= nWeb;
        resOutPort <= nPortIn ^ 1'b1;
        resCode    <= nWeb ? 8'd0 : 8'd1;
        resTag     <= nWeb ? WEB_TAG : '0;
      end
    end
  end

  // R5: the ingress port latch changes only on a start word
  a_r5_port_latch: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take && !ctl.first |=> $stable(portIn));

  // R7: result fields do not move unless an end word is taken
  a_r7_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.last |=> $stable(resIsWeb) && $stable(resOutPort) && $stable(resTag));
endmodule

// File: rtl/web_flow_classifier.sv
module web_flow_classifier
  import webcls_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter logic [TAG_W-1:0] WEB_TAG = 16'h00A5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inSof,
  input  logic             inEof,
  input  logic             inPort,
  output logic             resValid,
  input  logic             resReady,
  output logic             resIsWeb,
  output logic             resOutPort,
  output logic [7:0]       resCode,
  output logic [TAG_W-1:0] resTag
);
  wordCtl_t ctl;

  webcls_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inReady(inReady), .resReady(resReady), .resValid(resValid), .ctl(ctl)
  );

  webcls_dp #(.TAG_W(TAG_W), .WEB_TAG(WEB_TAG)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inPort(inPort),
    .resIsWeb(resIsWeb), .resOutPort(resOutPort), .resCode(resCode),
    .resTag(resTag)
  );

  // R6: the code agrees with the web flag whenever a result is offered
  a_r6_code_matches: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resCode == (resIsWeb ? 8'd0 : 8'd1)));
endmodule

// File: tb/web_flow_classifier_bench.sv
module web_flow_classifier_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0, inPort = 1'b0;
  logic        inReady, resValid, resIsWeb, resOutPort;
  logic        resReady = 1'b0;
  logic [7:0]  resCode;
  logic [15:0] resTag;

  int checks = 0;
  int fails  = 0;
  logic [31:0] frm [0:31];

  always #2 clk = ~clk;   // 250 MHz

  web_flow_classifier u_web_flow_classifier (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inReady(inReady), .inSof(inSof), .inEof(inEof), .inPort(inPort),
    .resValid(resValid), .resReady(resReady), .resIsWeb(resIsWeb),
    .resOutPort(resOutPort), .resCode(resCode), .resTag(resTag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic buildFrame(input logic [15:0] etype, input logic [3:0] ihlV,
                            input logic [7:0] proto, input logic [15:0] sport,
                            input logic [15:0] dport);
    for (int i = 0; i < 32; i++) frm[i] = 32'h1000_0000 + i;
    frm[3] = {etype, 4'h4, ihlV, 8'h00};
    if (ihlV >= 4'd5) begin
      frm[ihlV+3] = {16'hBEEF, sport};
      frm[ihlV+4] = {dport, 16'h7777};
    end else begin
      frm[ihlV+4] = {dport, 16'h7777};
    end
    frm[5] = {24'h112233, proto};
  endtask

  task automatic sendFrame(input int nWords, input logic port, input int gap);
    for (int i = 0; i < nWords; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); inValid = 1'b0;
      end
      @(negedge clk);
      inValid = 1'b1; inData = frm[i];
      inSof = (i == 0); inEof = (i == nWords - 1);
      inPort = (i == 0) ? port : ~port;
      @(posedge clk);
      while (!inReady) @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  task automatic expectResult(input string req, input bit web, input logic oport);
    chk(resValid == 1'b1, req, resValid, 1);
    chk(resIsWeb == web, req, resIsWeb, web);
    chk(resOutPort == oport, "R5", resOutPort, oport);
    chk(resCode == (web ? 8'd0 : 8'd1), "R6", resCode, web ? 0 : 1);
    chk(resTag == (web ? 16'h00A5 : 16'h0), "R6", resTag, web ? 16'hA5 : 0);
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    chk(resValid == 1'b0, "R7", resValid, 0);
  endtask

  task automatic testReset;
    chk(resValid == 1'b0, "R7", resValid, 0);
    chk(inReady == 1'b1, "R8", inReady, 1);
  endtask

  task automatic testBasicWeb;   // R1
    buildFrame(16'h0800, 4'd5, 8'd6, 16'd1234, 16'd80);
    sendFrame(12, 1'b1, 0);
    expectResult("R1", 1'b1, 1'b0);
  endtask

  task automatic testOptionsGaps;   // R2, R8
    buildFrame(16'h0800, 4'd7, 8'd6, 16'd555, 16'd80);
    sendFrame(14, 1'b0, 2);
    expectResult("R2", 1'b1, 1'b1);
  endtask

  task automatic testBadFields;   // R1
    buildFrame(16'h86DD, 4'd5, 8'd6, 16'd1, 16'd80);
    sendFrame(12, 1'b0, 0);
    expectResult("R1", 1'b0, 1'b1);
    buildFrame(16'h0800, 4'd5, 8'd17, 16'd1, 16'd80);
    sendFrame(12, 1'b1, 0);
    expectResult("R1", 1'b0, 1'b0);
  endtask

  task automatic testSrcDecoy;   // R2
    buildFrame(16'h0800, 4'd6, 8'd6, 16'd80, 16'd443);
    sendFrame(12, 1'b0, 1);
    expectResult("R2", 1'b0, 1'b1);
  endtask

  task automatic testShortIhl;   // R3
    buildFrame(16'h0800, 4'd3, 8'd6, 16'd0, 16'd80);
    frm[7] = {16'd80, 16'd80};
    sendFrame(12, 1'b1, 0);
    expectResult("R3", 1'b0, 1'b0);
  endtask

  task automatic testTruncated;   // R4
    buildFrame(16'h0800, 4'd5, 8'd6, 16'd1, 16'd80);
    sendFrame(9, 1'b0, 0);
    expectResult("R4", 1'b0, 1'b1);
  endtask

  task automatic testHoldAndStray;   // R7, R8, R9
    buildFrame(16'h0800, 4'd5, 8'd6, 16'd9, 16'd80);
    sendFrame(10, 1'b0, 0);
    repeat (3) @(negedge clk);
    chk(resValid && resIsWeb && resTag == 16'h00A5, "R7", resValid, 1);
    chk(inReady == 1'b0, "R8", inReady, 0);
    expectResult("R7", 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = 32'h0800_4500; inEof = (i == 3);
    end
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0;
    repeat (2) @(negedge clk);
    chk(resValid == 1'b0, "R9", resValid, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicWeb();
    testOptionsGaps();
    testBadFields();
    testSrcDecoy();
    testShortIhl();
    testTruncated();
    testHoldAndStray();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule